// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shifter

This block is the logic core of a display row driver. A single scan token travels along a chain of gate lines and moves one line on each rising edge of the shift clock. A static direction input chooses the end where the token enters and the end where it leaves. When the token leaves the far end, it is handed to the next device in the cascade. A static length input chooses between the full chain and a shortened chain. The shortened chain steps over a fixed group of lines in the middle, and those lines stay inactive.

The two serial pins are shared. With direction high, pin A carries the input and pin B carries the cascade output. With direction low, the two roles swap. Each pin is modelled as separate in, out and drive-enable ports. The cascade output is registered on the falling edge of the clock, so the next device sees stable data at its following rising edge. A mask input forces every gate line low at any moment, without waiting for a clock, and leaves the stored scan state untouched. Gate outputs are plain logic levels.

Top module: `gate_scan_shifter`

## Requirements
- R1: While rst_ni is low, all stages, all gate outputs and both pin outputs are 0, regardless of the other inputs.
- R2: With dir_i=1, pin_a_i is sampled into line 1 (gate_o[0]) on each rising edge, and each line k takes the value of line k-1 on the same edge.
- R3: With dir_i=0, pin_b_i is sampled into line N (gate_o[N-1]) on each rising edge, and each line k takes the value of line k+1 on the same edge.
- R4: With dir_i=1, pin_b_oe_o=1, pin_a_oe_o=0, pin_a_o=0, and pin_b_o carries the cascade. With dir_i=0, the roles are mirrored. The pin configured as output is never sampled.
- R5: With full_i=0, lines 171 to 178 (gate_o[177:170]) stay 0. The token steps directly from line 170 to line 179 when dir_i=1, and from line 179 to line 170 when dir_i=0.
- R6: On each falling edge, the cascade output register loads the last stage: line N when dir_i=1, line 1 when dir_i=0. A token sampled at rising edge 1 first shows on the cascade pin after the falling edge that follows rising edge 350 (full) or 342 (shortened).
- R7: While oe_mask_i=1, every gate output is 0. This takes effect combinationally, without a clock edge.
- R8: Masking does not alter the stored contents. Once oe_mask_i falls, the gate outputs show the chain exactly as it would be if no mask had been applied.
- R9: Several tokens in the chain keep their spacing as they shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_i | input | 1 | Scan direction: 1 = line 1 to N, 0 = line N to 1 (static) |
| full_i | input | 1 | Chain length: 1 = all N lines, 0 = skip the middle group (static) |
| oe_mask_i | input | 1 | 1 forces all gate outputs low |
| pin_a_i | input | 1 | Shared pin A, input path |
| pin_a_o | output | 1 | Shared pin A, output path |
| pin_a_oe_o | output | 1 | Shared pin A drive enable |
| pin_b_i | input | 1 | Shared pin B, input path |
| pin_b_o | output | 1 | Shared pin B, output path |
| pin_b_oe_o | output | 1 | Shared pin B drive enable |
| gate_o | output | N_LINES | Gate line levels; bit k-1 is line k |

## Verification
The in-line assertions check, on every cycle, the following behaviours:
- the sampling of the entry stage in both directions;
- the hop of one position per edge;
- the bypass across the skipped group, and the skipped group staying clear;
- the cascade register loading at falling edges;
- the pin roles;
- the mask forcing the lines low.

Some properties need whole scenarios, so only the bench can show them:
- the end-to-end latency of 350 or 342 clocks;
- the mask acting between clock edges;
- the chain contents surviving a masked interval;
- token spacing holding across long random streams in all four configurations.

// File: rtl/gss_pkg.sv
package gss_pkg;
  function automatic bit gss_in_gap(int idx, int lo, int cnt);
    return (idx >= lo) && (idx < lo + cnt);
  endfunction
endpackage

// File: rtl/gss_chain.sv
module gss_chain #(
  parameter int N_LINES = 350,
  parameter int GAP_LO  = 170,
  parameter int GAP_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fwd_i,
  input  logic               full_i,
  input  logic               din_i,
  output logic [N_LINES-1:0] stage_o
);
  import gss_pkg::*;

  localparam int GAP_HI = GAP_LO + GAP_CNT - 1;
  localparam int BEFORE = GAP_LO - 1;
  localparam int AFTER  = GAP_HI + 1;

  logic [N_LINES-1:0] s_q, d_w;

  for (genvar i = 0; i < N_LINES; i++) begin : g_stage
    logic up_v, dn_v;
    if (i == 0)            assign up_v = din_i;
    else if (i == AFTER)   assign up_v = full_i ? s_q[i-1] : s_q[BEFORE];
    else                   assign up_v = s_q[i-1];

    if (i == N_LINES-1)    assign dn_v = din_i;
    else if (i == BEFORE)  assign dn_v = full_i ? s_q[i+1] : s_q[AFTER];
    else                   assign dn_v = s_q[i+1];

    if (gss_in_gap(i, GAP_LO, GAP_CNT)) begin : g_gap
      assign d_w[i] = full_i & (fwd_i ? up_v : dn_v);
    end else begin : g_norm
      assign d_w[i] = fwd_i ? up_v : dn_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= d_w;
  end

  assign stage_o = s_q;

  a_r2_fwd_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_i |=> s_q[0] == $past(din_i));
  a_r3_rev_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_i |=> s_q[N_LINES-1] == $past(din_i));
  a_r9_fwd_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_i |=> s_q[N_LINES-1] == $past(s_q[N_LINES-2]));
  a_r9_rev_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_i |=> s_q[0] == $past(s_q[1]));
  a_r5_jump_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_i && !full_i) |=> s_q[AFTER] == $past(s_q[BEFORE]));
  a_r5_jump_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwd_i && !full_i) |=> s_q[BEFORE] == $past(s_q[AFTER]));
  a_r5_gap_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_i |=> s_q[GAP_HI:GAP_LO] == '0);
endmodule

// File: rtl/gss_cascade.sv
module gss_cascade (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic last_i,
  output logic casc_o
);
  // falling-edge register: next device samples on its rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) casc_o <= 1'b0;
    else         casc_o <= last_i;
  end

  a_r6_casc_load: assert property (@(negedge clk_i) disable iff (!rst_ni)
    casc_o == $past(last_i));
endmodule

// File: rtl/gss_gate_mask.sv
module gss_gate_mask #(
  parameter int N_LINES = 350,
  parameter int GAP_LO  = 170,
  parameter int GAP_CNT = 8
) (
  input  logic [N_LINES-1:0] stage_i,
  input  logic               mask_i,
  input  logic               full_i,
  output logic [N_LINES-1:0] gate_o
);
  import gss_pkg::*;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (gss_in_gap(i, GAP_LO, GAP_CNT)) begin : g_gap
      assign gate_o[i] = ~mask_i & full_i & stage_i[i];
    end else begin : g_norm
      assign gate_o[i] = ~mask_i & stage_i[i];
    end
  end
endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter #(
  parameter int N_LINES   = 350,
  parameter int GAP_FIRST = 171,
  parameter int GAP_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dir_i,
  input  logic               full_i,
  input  logic               oe_mask_i,
  input  logic               pin_a_i,
  output logic               pin_a_o,
  output logic               pin_a_oe_o,
  input  logic               pin_b_i,
  output logic               pin_b_o,
  output logic               pin_b_oe_o,
  output logic [N_LINES-1:0] gate_o
);
  localparam int GAP_LO = GAP_FIRST - 1;

  logic [N_LINES-1:0] stage_w;
  logic din_w, last_w, casc_w;

  assign din_w  = dir_i ? pin_a_i : pin_b_i;
  assign last_w = dir_i ? stage_w[N_LINES-1] : stage_w[0];

  gss_chain #(.N_LINES(N_LINES), .GAP_LO(GAP_LO), .GAP_CNT(GAP_LINES)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fwd_i  (dir_i),
    .full_i (full_i),
    .din_i  (din_w),
    .stage_o(stage_w)
  );

  gss_cascade u_casc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .last_i(last_w),
    .casc_o(casc_w)
  );

  gss_gate_mask #(.N_LINES(N_LINES), .GAP_LO(GAP_LO), .GAP_CNT(GAP_LINES)) u_mask (
    .stage_i(stage_w),
    .mask_i (oe_mask_i),
    .full_i (full_i),
    .gate_o (gate_o)
  );

  assign pin_a_oe_o = ~dir_i;
  assign pin_b_oe_o = dir_i;
  assign pin_a_o    = ~dir_i & casc_w;
  assign pin_b_o    = dir_i & casc_w;

  a_r4_pin_roles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_i ? (!pin_a_o && pin_b_oe_o && !pin_a_oe_o) : (!pin_b_o && pin_a_oe_o && !pin_b_oe_o));
  a_r7_mask_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_mask_i |-> gate_o == '0);
endmodule

// File: tb/tb_gate_scan_shifter.sv
`timescale 1ns/1ps
module tb_gate_scan_shifter;
  localparam int N       = 350;
  localparam int GAP_LO  = 170;
  localparam int GAP_CNT = 8;
  localparam int GAP_HI  = GAP_LO + GAP_CNT - 1;
  localparam int BEFORE  = GAP_LO - 1;
  localparam int AFTER   = GAP_HI + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dir = 1'b1, full = 1'b1, oe = 1'b0, din = 1'b0, garb = 1'b0;
  logic pin_a_o, pin_a_oe_o, pin_b_o, pin_b_oe_o;
  logic [N-1:0] gate_o;
  logic [N-1:0] ref_q = '0;
  logic ref_casc = 1'b0;
  int edge_cnt = 0, first_hi = 0, n_tests = 0, n_fail = 0;
  int unsigned seed_v;

  gate_scan_shifter #(.N_LINES(N), .GAP_FIRST(GAP_LO + 1), .GAP_LINES(GAP_CNT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .dir_i(dir), .full_i(full), .oe_mask_i(oe),
    .pin_a_i(dir ? din : garb), .pin_a_o(pin_a_o), .pin_a_oe_o(pin_a_oe_o),
    .pin_b_i(dir ? garb : din), .pin_b_o(pin_b_o), .pin_b_oe_o(pin_b_oe_o),
    .gate_o(gate_o)
  );

  always #10 clk = ~clk;

  task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %h expected %h", req, edge_cnt, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, edge_cnt, act, exp);
    end
  endtask

  function automatic bit in_gap(int i);
    return i >= GAP_LO && i <= GAP_HI;
  endfunction

  // reference chain step taken from R2, R3, R5
  task automatic model_edge();
    logic [N-1:0] nxt = '0;
    for (int i = 0; i < N; i++) begin
      int src;
      if (!full && in_gap(i)) continue;
      if (dir) begin
        src = i - 1;
        if (!full && i == AFTER) src = BEFORE;
      end else begin
        src = i + 1;
        if (!full && i == BEFORE) src = AFTER;
      end
      nxt[i] = (src < 0 || src >= N) ? din : ref_q[src];
    end
    ref_q = nxt;
  endtask

  function automatic logic [N-1:0] exp_gate();
    return oe ? '0 : ref_q;
  endfunction

  function automatic string cfg_tag();
    return full ? (dir ? "R2 R9" : "R3 R9") : (dir ? "R2 R5" : "R3 R5");
  endfunction

  task automatic step(input logic nd, input logic noe);
    @(posedge clk);
    edge_cnt++;
    model_edge();
    #5;
    chk_vec(cfg_tag(), gate_o, exp_gate());
    din = nd; oe = noe; garb = 1'($urandom(seed_v) & 1);
    @(negedge clk);
    ref_casc = dir ? ref_q[N-1] : ref_q[0];
    #2;
    chk_int("R6 R4", dir ? int'(pin_b_o) : int'(pin_a_o), int'(ref_casc));
    chk_int("R4", dir ? int'(pin_a_o) : int'(pin_b_o), 0);
    chk_int("R4", int'({pin_a_oe_o, pin_b_oe_o}), dir ? 1 : 2);
    if (first_hi == 0 && (dir ? pin_b_o : pin_a_o)) first_hi = edge_cnt;
  endtask

  task automatic do_reset();
    @(posedge clk);
    #5 rst_ni = 1'b0;
    ref_q = '0; ref_casc = 1'b0; edge_cnt = 0; first_hi = 0; din = 1'b0; oe = 1'b0;
    #1;
    chk_vec("R1", gate_o, '0);
    chk_int("R1", int'({pin_a_o, pin_b_o}), 0);
    @(posedge clk);
    #5 rst_ni = 1'b1;
  endtask

  task automatic async_mask_probe();
    logic keep = oe;
    oe = 1'b1; #1;
    chk_vec("R7", gate_o, '0);
    oe = 1'b0; #1;
    chk_vec("R8", gate_o, ref_q);
    oe = keep;
  endtask

  task automatic run_token(input logic d, input logic f);
    int len = f ? N : N - GAP_CNT;
    dir = d; full = f;
    do_reset();
    din = 1'b1;                              // sampled at edge 1
    for (int k = 1; k <= len + 4; k++) begin
      step(1'b0, 1'b0);
      if (!f && d && k == GAP_LO + 1)
        chk_vec("R5", gate_o & ~(1 << 0), ({{(N-1){1'b0}}, 1'b1} << AFTER));
      if (!f && !d && k == N - AFTER + 1)
        chk_vec("R5", gate_o, ({{(N-1){1'b0}}, 1'b1} << BEFORE));
      if (k == 200) async_mask_probe();
    end
    chk_int("R6", first_hi, len);
  endtask

  task automatic run_random(input logic d, input logic f, input int cycles);
    dir = d; full = f;
    do_reset();
    for (int k = 0; k < cycles; k++) begin
      step(($urandom(seed_v) % 4) == 0, ($urandom(seed_v) % 8) == 0);
      if (($urandom(seed_v) % 16) == 0) async_mask_probe();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    seed_v = 32'd1234;
    din = 1'b1; oe = 1'b0;
    #3;
    chk_vec("R1", gate_o, '0);
    chk_int("R1", int'({pin_a_o, pin_b_o}), 0);
    run_token(1'b1, 1'b1);
    run_token(1'b0, 1'b1);
    run_token(1'b1, 1'b0);
    run_token(1'b0, 1'b0);
    run_random(1'b1, 1'b1, 400);
    run_random(1'b0, 1'b0, 400);
    run_random(1'b1, 1'b0, 400);
    run_random(1'b0, 1'b1, 400);
    do_reset();                              // R1 mid-run clear
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule